// File: doc/BRIEF.md
# Packed Decimal to Binary Integer Converter

This block converts in both directions between a ten-byte packed-decimal operand and a signed 64-bit two's-complement integer. The decimal operand keeps eighteen decimal digits in its nine lower bytes. Each of those bytes holds two digits, and the upper nibble is the more significant one. The top byte carries the sign in its bit 7. A caller picks the direction with `mode_store`, presents the whole operand word and pulses `start`. The block then works one byte per clock and raises `done` for a single cycle when the result is ready.

In decimal-to-binary direction, the block walks the digit bytes from the most significant end and multiplies a running value by one hundred at each step. It applies the sign last. In binary-to-decimal direction, the block first emits the sign byte. It then peels the magnitude into digit pairs from the least significant byte upward, and also streams each byte on a byte-wide port as it is formed. Floating-point conversion and memory access belong to the surrounding logic.

Top module: `bcd_int_conv`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `busy`, `done`, `byte_valid`, `ld_bad_digit` and `st_overflow` are 0, and `ld_result` and `st_result` are all zeros.
- R2: In load mode (`mode_store`=0), the result is the integer whose decimal digits are, from most to least significant: the upper nibble of byte 8, the lower nibble of byte 8, and so on down to the lower nibble of byte 0. Byte k is `ld_operand[8k+7:8k]`.
- R3: In load mode, bit 7 of byte 9 set makes `ld_result` the two's-complement negation of the magnitude. Bits 6:0 of byte 9 have no effect.
- R4: In load mode, a nibble above 9 in bytes 0..8 is still used arithmetically. Each step computes value×100 + upper×10 + lower, modulo 2^64. Such a nibble also sets `ld_bad_digit` for that conversion.
- R5: In store mode, byte 9 of `st_result` is 0x80 when `st_value` is negative and 0x00 otherwise, zero included.
- R6: In store mode, byte k (k=0..8) of `st_result` holds floor(|v|/100^k) mod 100. Its tens digit is in bits 7:4 and its units digit is in bits 3:0. Bytes above the last non-zero digit pair are 0x00.
- R7: In store mode, a magnitude of 10^18 or more sets `st_overflow`. The digit bytes then hold |v| mod 10^18. The most negative input has magnitude 2^63.
- R8: In store mode, `byte_valid` is high for ten consecutive cycles. `byte_idx`/`byte_data` carry byte 9 first, then bytes 0 to 8 in increasing order. Load mode raises no `byte_valid`.
- R9: `start` is accepted at a clock edge while idle. `busy` is then high until `done` rises exactly ten edges later. `done` lasts one cycle, with `busy` already low.
- R10: A `start` pulse while `busy` is high is ignored. The running conversion finishes unchanged and on time.
- R11: `ld_result`/`ld_bad_digit` change only when a load finishes. `st_result`/`st_overflow` change only when a store finishes. Each holds its value until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion (accepted while idle) |
| mode_store | input | 1 | 0: decimal to binary, 1: binary to decimal |
| ld_operand | input | 80 | Packed-decimal operand, byte 9 = sign |
| st_value | input | 64 | Signed integer to convert |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_result | output | 64 | Signed binary result of the last load |
| ld_bad_digit | output | 1 | Last load saw a nibble above 9 |
| st_result | output | 80 | Packed-decimal result of the last store |
| st_overflow | output | 1 | Last store magnitude needed more than 18 digits |
| byte_valid | output | 1 | Store byte stream strobe |
| byte_idx | output | 4 | Index of the streamed byte |
| byte_data | output | 8 | Streamed byte value |

## Verification
The assertions assume that the operand inputs are meaningful only at the edge that accepts `start`. They also assume that `start` comes from the same clock domain, so the latency counter and the stream-order check start from a clean accept.

The bench changes `ld_operand` and `st_value` only together with a `start` pulse, on the falling edge. The load sweep runs every byte value through every digit position with both signs and with junk in the low sign bits. The store stimulus covers each power of ten, its neighbours on both sides and both extremes. The stimulus includes one deliberate `start` during a busy load to exercise the ignore rule.

// File: rtl/bcdc_pkg.sv
// Package: shared state encoding and constants for the packed-decimal converter.
// Assumes widths up to 128 bits for the overflow limit computation.
package bcdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_ACC,
        ST_LD_SIGN,
        ST_SR_SIGN,
        ST_SR_DIG
    } bcdc_state_e;

    localparam logic [7:0] SIGN_NEG = 8'h80;
    localparam logic [7:0] SIGN_POS = 8'h00;

    // Returns 100^pairs, the first magnitude that no longer fits the digit bytes.
    function automatic logic [127:0] dec_limit(input int unsigned pairs);
        logic [127:0] r;
        r = 128'd1;
        for (int unsigned i = 0; i < pairs; i++) begin
            r = r * 128'd100;
        end
        return r;
    endfunction

endpackage

// File: rtl/bcdc_ctrl.sv
// Sequencer: walks the byte index for both directions and times the done pulse.
// Assumes start is synchronous; start seen while busy is ignored.
module bcdc_ctrl
    import bcdc_pkg::*;
#(
    parameter int DIG_BYTES = 9,
    localparam int IDX_W    = $clog2(DIG_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_store,
    output bcdc_state_e      state,
    output logic [IDX_W-1:0] idx,
    output logic             accept,
    output logic             busy,
    output logic             done
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIG_BYTES - 1);

    assign accept = (state == ST_IDLE) && start;
    assign busy   = (state != ST_IDLE);

    // Next-state, byte index and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= mode_store ? ST_SR_SIGN : ST_LD_ACC;
                        idx   <= mode_store ? '0 : IDX_LAST;
                    end
                end
                ST_LD_ACC: begin
                    if (idx == '0) state <= ST_LD_SIGN;
                    else           idx   <= idx - 1'b1;
                end
                ST_LD_SIGN: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                ST_SR_SIGN: begin
                    state <= ST_SR_DIG;
                    idx   <= '0;
                end
                ST_SR_DIG: begin
                    if (idx == IDX_LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

endmodule

// File: rtl/bcdc_load_step.sv
// One load step: value*100 + upper*10 + lower, modulo 2^BIN_W.
// Also flags either nibble above 9; the arithmetic uses the raw nibbles regardless.
module bcdc_load_step #(
    parameter int BIN_W = 64
) (
    input  logic [BIN_W-1:0] acc,
    input  logic [7:0]       pair,
    output logic [BIN_W-1:0] acc_nxt,
    output logic             bad
);

    logic [3:0] hi;
    logic [3:0] lo;

    assign hi = pair[7:4];
    assign lo = pair[3:0];

    // Multiply-accumulate of one digit pair.
    always_comb begin
        acc_nxt = acc * BIN_W'(100) + BIN_W'(hi) * BIN_W'(10) + BIN_W'(lo);
        bad     = (hi > 4'd9) || (lo > 4'd9);
    end

endmodule

// File: rtl/bcdc_store_step.sv
// One store step: split magnitude into (mag mod 100) as two digits and mag/100.
// Assumes an unsigned magnitude; constant divisors only.
module bcdc_store_step #(
    parameter int BIN_W = 64
) (
    input  logic [BIN_W-1:0] mag,
    output logic [7:0]       pair,
    output logic [BIN_W-1:0] mag_nxt
);

    logic [6:0] rem;

    // Remainder digits and quotient of the constant division.
    always_comb begin
        rem     = 7'(mag % BIN_W'(100));
        pair    = {4'(rem / 7'd10), 4'(rem % 7'd10)};
        mag_nxt = mag / BIN_W'(100);
    end

endmodule

// File: rtl/bcd_int_conv.sv
// Top: bidirectional packed-decimal <-> signed binary integer converter.
// One byte per clock in both directions; done follows start by DIG_BYTES+1 edges.
// Assumes operand inputs are sampled only on the accepting edge.
module bcd_int_conv
    import bcdc_pkg::*;
#(
    parameter int DIG_BYTES = 9,
    parameter int BIN_W     = 64,
    localparam int OPW      = 8 * (DIG_BYTES + 1),
    localparam int IDX_W    = $clog2(DIG_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_store,
    input  logic [OPW-1:0]   ld_operand,
    input  logic [BIN_W-1:0] st_value,
    output logic             busy,
    output logic             done,
    output logic [BIN_W-1:0] ld_result,
    output logic             ld_bad_digit,
    output logic [OPW-1:0]   st_result,
    output logic             st_overflow,
    output logic             byte_valid,
    output logic [IDX_W-1:0] byte_idx,
    output logic [7:0]       byte_data
);

    localparam logic [127:0]     MAG_LIMIT = dec_limit(DIG_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DIG_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_SIGN  = IDX_W'(DIG_BYTES);
    localparam int               LATENCY   = DIG_BYTES + 1;

    bcdc_state_e      state;
    logic [IDX_W-1:0] idx;
    logic             accept;

    logic [OPW-1:0]   op_q;
    logic [BIN_W-1:0] acc_q;
    logic             neg_q;
    logic             bad_w;
    logic             ovf_w;
    logic [BIN_W-1:0] mag_q;
    logic [OPW-1:0]   wrk_q;
    logic [OPW-1:0]   wrk_upd;

    logic [7:0]       ld_pair;
    logic [BIN_W-1:0] acc_nxt;
    logic             ld_bad;
    logic [7:0]       st_pair;
    logic [BIN_W-1:0] mag_nxt;
    logic [BIN_W-1:0] in_abs;

    bcdc_ctrl #(.DIG_BYTES(DIG_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_store (mode_store),
        .state      (state),
        .idx        (idx),
        .accept     (accept),
        .busy       (busy),
        .done       (done)
    );

    assign ld_pair = op_q[8*int'(idx) +: 8];

    bcdc_load_step #(.BIN_W(BIN_W)) u_ld (
        .acc     (acc_q),
        .pair    (ld_pair),
        .acc_nxt (acc_nxt),
        .bad     (ld_bad)
    );

    bcdc_store_step #(.BIN_W(BIN_W)) u_st (
        .mag     (mag_q),
        .pair    (st_pair),
        .mag_nxt (mag_nxt)
    );

    // Magnitude of the store input; the most negative value maps to 2^(BIN_W-1).
    assign in_abs = st_value[BIN_W-1] ? (~st_value + 1'b1) : st_value;

    // Working packed word with the current digit pair merged in.
    always_comb begin
        wrk_upd = wrk_q;
        wrk_upd[8*int'(idx) +: 8] = st_pair;
    end

    // Operand capture and per-step working state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            acc_q <= '0;
            neg_q <= 1'b0;
            bad_w <= 1'b0;
            ovf_w <= 1'b0;
            mag_q <= '0;
            wrk_q <= '0;
        end else if (accept) begin
            op_q  <= ld_operand;
            acc_q <= '0;
            bad_w <= 1'b0;
            neg_q <= mode_store ? st_value[BIN_W-1] : ld_operand[OPW-1];
            mag_q <= in_abs;
            ovf_w <= mode_store && (128'(in_abs) >= MAG_LIMIT);
            wrk_q <= '0;
        end else begin
            case (state)
                ST_LD_ACC: begin
                    acc_q <= acc_nxt;
                    bad_w <= bad_w | ld_bad;
                end
                ST_SR_SIGN: wrk_q[OPW-1 -: 8] <= neg_q ? SIGN_NEG : SIGN_POS;
                ST_SR_DIG: begin
                    wrk_q <= wrk_upd;
                    mag_q <= mag_nxt;
                end
                default: ;
            endcase
        end
    end

    // Result registers, updated only when their direction completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_result    <= '0;
            ld_bad_digit <= 1'b0;
            st_result    <= '0;
            st_overflow  <= 1'b0;
        end else if (state == ST_LD_SIGN) begin
            ld_result    <= neg_q ? (~acc_q + 1'b1) : acc_q;
            ld_bad_digit <= bad_w;
        end else if (state == ST_SR_DIG && idx == IDX_LAST) begin
            st_result    <= wrk_upd;
            st_overflow  <= ovf_w;
        end
    end

    // Byte stream of the store direction, sign byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_idx   <= '0;
            byte_data  <= '0;
        end else if (state == ST_SR_SIGN) begin
            byte_valid <= 1'b1;
            byte_idx   <= IDX_SIGN;
            byte_data  <= neg_q ? SIGN_NEG : SIGN_POS;
        end else if (state == ST_SR_DIG) begin
            byte_valid <= 1'b1;
            byte_idx   <= idx;
            byte_data  <= st_pair;
        end else begin
            byte_valid <= 1'b0;
        end
    end

    // Cycle counter from accept, used only by the latency check.
    logic [7:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (accept) lat_q <= '0;
        else if (busy)   lat_q <= lat_q + 1'b1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 8'(LATENCY))); // R9
    AST_SIGN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_idx == IDX_SIGN) |-> (byte_data[6:0] == 7'd0)); // R5
    AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_idx != IDX_SIGN) |->
            (byte_data[7:4] <= 4'd9 && byte_data[3:0] <= 4'd9)); // R6
    AST_STREAM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_idx != IDX_SIGN) |-> $past(byte_valid)); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done)); // R10

endmodule

// File: tb/bcd_int_conv_tb.sv
`timescale 1ns/1ps
module bcd_int_conv_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_store = 1'b0;
    logic [79:0] ld_operand = '0;
    logic [63:0] st_value = '0;
    logic        busy, done, ld_bad_digit, st_overflow, byte_valid;
    logic [63:0] ld_result;
    logic [79:0] st_result;
    logic [3:0]  byte_idx;
    logic [7:0]  byte_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    int          cyc;
    int          nstream;
    bit          busy_bad;
    logic [3:0]  sidx [0:15];
    logic [7:0]  sdat [0:15];

    bcd_int_conv u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_store(mode_store),
        .ld_operand(ld_operand), .st_value(st_value), .busy(busy), .done(done),
        .ld_result(ld_result), .ld_bad_digit(ld_bad_digit), .st_result(st_result),
        .st_overflow(st_overflow), .byte_valid(byte_valid), .byte_idx(byte_idx),
        .byte_data(byte_data)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one conversion and capture latency and byte stream.
    task automatic run(input bit m, input logic [79:0] op, input logic [63:0] v, input bit poke);
        @(negedge clk);
        start = 1'b1; mode_store = m; ld_operand = op; st_value = v;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; nstream = 0; busy_bad = 0;
        while (!done && cyc < 40) begin
            if (!busy) busy_bad = 1;
            if (poke && cyc == 4) begin
                start = 1'b1; mode_store = ~m; ld_operand = ~op; st_value = ~v;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (byte_valid && nstream < 16) begin
                sidx[nstream] = byte_idx;
                sdat[nstream] = byte_data;
                nstream++;
            end
        end
        start = 1'b0;
        chk(cyc == 10 && !busy_bad, "R9 latency/busy", 80'(cyc), 80'd10);
        @(negedge clk);
        chk(!done, "R9 done one cycle", 80'(done), 80'd0);
    endtask

    task automatic do_load(input logic [79:0] op, input bit poke);
        logic [63:0] e;
        bit          bad;
        e = '0; bad = 0;
        for (int b = 8; b >= 0; b--) begin
            logic [3:0] hi, lo;
            hi = op[8*b+4 +: 4]; lo = op[8*b +: 4];
            if (hi > 9 || lo > 9) bad = 1;
            e = e * 64'd100 + 64'(hi) * 64'd10 + 64'(lo);
        end
        if (op[79]) e = -e;
        run(1'b0, op, 64'h0, poke);
        chk(ld_result == e, op[79] ? "R3 load negative" : "R2 load value", 80'(ld_result), 80'(e));
        chk(ld_bad_digit == bad, "R4 bad digit flag", 80'(ld_bad_digit), 80'(bad));
        chk(nstream == 0, "R8 no stream in load", 80'(nstream), 80'd0);
    endtask

    task automatic do_store(input logic [63:0] v);
        logic [63:0] mag;
        logic [79:0] e;
        bit          ovf;
        mag = v[63] ? -v : v;
        ovf = (mag >= 64'd1000000000000000000);
        e = '0;
        e[79:72] = v[63] ? 8'h80 : 8'h00;
        for (int k = 0; k < 9; k++) begin
            int unsigned r;
            r = int'(mag % 64'd100);
            e[8*k +: 8] = {4'(r / 10), 4'(r % 10)};
            mag = mag / 64'd100;
        end
        run(1'b1, 80'h0, v, 1'b0);
        chk(st_result[79:72] == e[79:72], "R5 sign byte", 80'(st_result[79:72]), 80'(e[79:72]));
        chk(st_result[71:0] == e[71:0], "R6 digit bytes", st_result, e);
        chk(st_overflow == ovf, "R7 overflow", 80'(st_overflow), 80'(ovf));
        chk(nstream == 10, "R8 stream length", 80'(nstream), 80'd10);
        if (nstream == 10) begin
            chk(sidx[0] == 4'd9 && sdat[0] == e[79:72], "R8 sign first",
                {sidx[0], sdat[0]}, {4'd9, e[79:72]});
            for (int k = 1; k < 10; k++)
                chk(sidx[k] == 4'(k-1) && sdat[k] == e[8*(k-1) +: 8], "R8 stream order",
                    {sidx[k], sdat[k]}, {4'(k-1), e[8*(k-1) +: 8]});
        end
    endtask

    initial begin
        logic [79:0] op;
        logic [63:0] p10;
        logic [63:0] lf;
        logic [79:0] keep_st;
        logic [63:0] keep_ld;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !byte_valid && !ld_bad_digit && !st_overflow,
            "R1 reset flags", {busy, done, byte_valid, ld_bad_digit, st_overflow}, 80'd0);
        chk(ld_result == 0 && st_result == 0, "R1 reset results", st_result | 80'(ld_result), 80'd0);
        rst_n = 1'b1;

        // R2/R3/R4 sweep: every byte value in every digit position, both signs
        for (int pos = 0; pos < 9; pos++) begin
            for (int v = 0; v < 256; v++) begin
                for (int s = 0; s < 2; s++) begin
                    op = '0;
                    for (int j = 0; j < 9; j++)
                        op[8*j +: 8] = {4'((j + pos) % 10), 4'((3*j + v) % 10)};
                    op[8*pos +: 8] = 8'(v);
                    op[79:72] = {1'(s), 7'(v)};
                    do_load(op, 1'b0);
                end
            end
        end
        do_load({8'h80, 72'h999999999999999999}, 1'b0);
        do_load({8'h7f, 72'h0}, 1'b0);

        // R5/R6/R7/R8 store: powers of ten, neighbours, extremes
        p10 = 64'd1;
        for (int p = 0; p <= 18; p++) begin
            do_store(p10 - 1); do_store(p10); do_store(p10 + 1);
            do_store(-(p10 - 1)); do_store(-p10); do_store(-(p10 + 1));
            p10 = p10 * 64'd10;
        end
        do_store(64'h0); do_store(64'h8000000000000000); do_store(64'h7fffffffffffffff);
        lf = 64'hace1_2345_6789_0bdf;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            do_store(lf >> (i % 64));
        end

        // R10 start while busy is ignored; R11 store results untouched by load
        keep_st = st_result;
        do_load({8'h80, 72'h123456789012345678}, 1'b1);
        chk(st_result == keep_st, "R11 store result held across load", st_result, keep_st);
        keep_ld = ld_result;
        do_store(64'd4242);
        chk(ld_result == keep_ld, "R11 load result held across store", 80'(ld_result), 80'(keep_ld));
        chk(ld_result == -64'd123456789012345678, "R10 busy start ignored",
            80'(ld_result), 80'(-64'd123456789012345678));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule